// File: doc/BRIEF.md
# Transmit Word Parser

The block takes the 32-bit words a host writes into a transmit FIFO port and works out what each one means. The first word of a buffer is a control word (command A). The second word is a tag word (command B). After that come the buffer's data words. The parser drops the leading byte offset of the buffer, and it drops whole words when that offset spans a full word or more. It sends the useful bytes out one per clock, least significant byte first, and swallows any alignment pad words that follow the data.

When a buffer carrying the last-segment mark finishes, the block does three things. It flags the final byte of the packet on the byte stream. It queues a status word holding the packet tag. It can also raise a sticky completion flag. The sticky flags report a full status queue and a write into a full data FIFO. A dump input throws away a partly parsed buffer.

The host must space its writes at least four clocks apart. That spacing lets the byte serializer empty a word before the next one arrives. The byte stream has no backpressure.

Top module: `tx_word_parser`

## Requirements
- R1: Out of reset, or after a buffer completes, the next accepted word is command A. The word after it is command B, and the words after that are data words.
- R2: Command A bit positions: bits 10:0 give the buffer size in bytes, bits 20:16 the start offset in bytes, bit 12 marks the last segment, bit 13 the first segment, bit 31 asks for a completion flag, and bits 25:24 select the end pad mode.
- R3: While the remaining start offset is 4 or more, each data word is consumed with no output and lowers the offset by 4.
- R4: A data word that meets a remaining offset of 1 to 3 loses that many low-order bytes. Bytes leave least significant first, one per clock, starting the clock after the write. A word emits at most as many bytes as remain in the buffer.
- R5: Let N be ceil((size+offset)/4). Pad mode 1 pads the data-word count up to a multiple of 4, and pad mode 2 up to a multiple of 8; other modes add no pad. Pad words produce no output, and the word after the last pad is command A.
- R6: out_last is high on the final byte of a buffer whose last-segment bit is set, and on no other byte.
- R7: When a last-segment buffer completes, bits 31:16 of the command B word are pushed into the status queue. A buffer without the last-segment bit pushes nothing.
- R8: A completion that finds the status queue full pushes nothing. A push that fills the queue sets the sticky irq_stat_full flag.
- R9: A completing buffer with bit 31 of command A set sets the sticky irq_done flag. Writing 1 to flag_clr bit 0 clears it, and a buffer without bit 31 leaves it unchanged.
- R10: Every accepted command and data word counts toward DATA_WORDS; offset-skip words do not. A write made when the count equals DATA_WORDS is ignored and sets the sticky irq_overflow flag (cleared by flag_clr bit 2). Completing a last-segment buffer or a dump zeroes the count.
- R11: dump returns the parser to wait for command A and stops any bytes still being serialized from the next clock on.
- R12: After reset, out_valid, stat_valid, stat_level and all three flags are zero.
- R13: A buffer without the first-segment bit does not replace the stored command B. The status of a multi-segment packet therefore carries the tag of its first segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write strobe for the transmit FIFO port |
| wr_data | input | 32 | Written word |
| dump | input | 1 | Discard the partly parsed buffer and return to wait for command A |
| stat_pop | input | 1 | Remove the head entry of the status queue |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 irq_done, bit 1 irq_stat_full, bit 2 irq_overflow |
| out_valid | output | 1 | Packet byte valid |
| out_byte | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |
| stat_valid | output | 1 | Status queue not empty |
| stat_word | output | 16 | Packet tag at the head of the status queue |
| stat_level | output | $clog2(STAT_DEPTH+1) | Number of entries in the status queue |
| irq_done | output | 1 | Sticky completion flag |
| irq_stat_full | output | 1 | Sticky status-queue-full flag |
| irq_overflow | output | 1 | Sticky write-while-full flag |

## Verification
The parser is driven with single-segment buffers of several shapes:
- zero offset;
- offset below one word, to separate low-byte dropping from whole-word skipping;
- offset above one word;
- both pad modes.

In each shape, the bytes that must not appear are unique garbage values (offset fill, tail fill past the size, and pad words). Any misplaced drop or extra byte therefore shows up in the scoreboard.

A two-segment packet, whose second tag word differs from the first, shows whether the first-segment bit gates the tag latch and whether out_last waits for the last segment. A run of back-to-back packets fills a small status queue and confirms that the overflowing tag is dropped. An oversized buffer fills the data FIFO count. A dump issued while bytes are still leaving checks that the flush takes effect at once.

// File: rtl/txp_pkg.sv
package txp_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_CMDB = 2'd1,
      PS_DATA = 2'd2
   } pstate_t;

   localparam int SIZE_W = 11;
   localparam int OFS_W  = 5;
   localparam int TAG_W  = 16;
   localparam logic [31:0] CMDA_KEEP = 32'h831F_37FF;

   function automatic logic [SIZE_W-1:0] a_size(input logic [31:0] a);
      return a[10:0];
   endfunction

   function automatic logic [OFS_W-1:0] a_ofs(input logic [31:0] a);
      return a[20:16];
   endfunction

   function automatic logic a_last(input logic [31:0] a);
      return a[12];
   endfunction

   function automatic logic a_first(input logic [31:0] a);
      return a[13];
   endfunction

   function automatic logic a_ioc(input logic [31:0] a);
      return a[31];
   endfunction

   function automatic logic [1:0] a_padm(input logic [31:0] a);
      return a[25:24];
   endfunction

   // pad words needed to round the data-word count to the selected multiple
   function automatic logic [2:0] pad_count(input logic [1:0] mode,
                                            input logic [SIZE_W-1:0] size,
                                            input logic [OFS_W-1:0] ofs);
      logic [SIZE_W+1:0] tot;
      logic [2:0]        neg;
      tot = {2'b00, size} + {{(SIZE_W+2-OFS_W){1'b0}}, ofs} + (SIZE_W+2)'(3);
      neg = 3'd0 - tot[4:2];
      case (mode)
         2'd1:    return {1'b0, neg[1:0]};
         2'd2:    return neg;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/txp_unpack.sv
module txp_unpack #(
   parameter int WORD_W = 32,
   localparam int NB    = WORD_W / 8,
   localparam int CW    = $clog2(NB + 1),
   localparam int DW    = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic [DW-1:0]     drop,
   input  logic [CW-1:0]     count,
   input  logic              last_in,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              out_last
);
   logic [WORD_W-1:0] sh;
   logic [CW-1:0]     cnt;
   logic              lst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         lst <= 1'b0;
      end else if (flush) begin
         cnt <= '0;
         lst <= 1'b0;
      end else if (load) begin
         sh  <= word >> {drop, 3'b000};
         cnt <= count;
         lst <= last_in;
      end else if (cnt != '0) begin
         sh  <= sh >> 8;
         cnt <= cnt - CW'(1);
      end
   end

   assign out_valid = (cnt != '0);
   assign out_byte  = sh[7:0];
   assign out_last  = lst && (cnt == CW'(1));

endmodule

// File: rtl/txp_stat_fifo.sv
module txp_stat_fifo #(
   parameter int DEPTH = 512,
   parameter int W     = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic          valid,
   output logic [W-1:0]  head,
   output logic [LW-1:0] level,
   output logic          full_hit
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("txp_stat_fifo: DEPTH must be at least 2");
   end

   assign do_push  = push && (level != LW'(DEPTH));
   assign do_pop   = pop && (level != '0);
   assign full_hit = do_push && !do_pop && (level == LW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         if (do_push && !do_pop)      level <= level + LW'(1);
         else if (do_pop && !do_push) level <= level - LW'(1);
      end
   end

   assign valid = (level != '0);
   assign head  = mem[rp];

endmodule

// File: rtl/tx_word_parser.sv
module tx_word_parser
   import txp_pkg::*;
#(
   parameter int DATA_WORDS = 4608,
   parameter int STAT_DEPTH = 512,
   localparam int SLW = $clog2(STAT_DEPTH + 1),
   localparam int UW  = $clog2(DATA_WORDS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_valid,
   input  logic [31:0]    wr_data,
   input  logic           dump,
   input  logic           stat_pop,
   input  logic [2:0]     flag_clr,
   output logic           out_valid,
   output logic [7:0]     out_byte,
   output logic           out_last,
   output logic           stat_valid,
   output logic [15:0]    stat_word,
   output logic [SLW-1:0] stat_level,
   output logic           irq_done,
   output logic           irq_stat_full,
   output logic           irq_overflow
);
   if (DATA_WORDS < 3) begin : g_bad_words
      $error("tx_word_parser: DATA_WORDS must be at least 3");
   end

   pstate_t           state;
   logic [31:0]       cmd_a, cmd_b;
   logic [SIZE_W-1:0] rem_size;
   logic [OFS_W-1:0]  rem_ofs;
   logic [2:0]        rem_pad;
   logic [UW-1:0]     used;

   logic        accept, ovf_set;
   logic        skip_word, pad_word, data_word;
   logic [2:0]  avail, nbytes;
   logic [SIZE_W-1:0] size_after;
   logic        finish, sent, ioc_set, emit_load, emit_last, full_hit;
   logic [2:0]  fset, flags;

   always_comb begin
      accept     = wr_valid && !dump && (used != UW'(DATA_WORDS));
      ovf_set    = wr_valid && !dump && (used == UW'(DATA_WORDS));
      skip_word  = (state == PS_DATA) && (rem_ofs >= OFS_W'(4));
      pad_word   = (state == PS_DATA) && !skip_word && (rem_size == '0) && (rem_pad != '0);
      data_word  = (state == PS_DATA) && !skip_word && !pad_word;
      avail      = 3'd4 - rem_ofs[2:0];
      nbytes     = (rem_size < SIZE_W'(avail)) ? rem_size[2:0] : avail;
      size_after = rem_size - SIZE_W'(nbytes);
      finish     = accept && ((pad_word && rem_pad == 3'd1) ||
                              (data_word && size_after == '0 && rem_pad == '0));
      sent       = finish && a_last(cmd_a);
      ioc_set    = finish && a_ioc(cmd_a);
      emit_load  = accept && data_word && (nbytes != '0);
      emit_last  = a_last(cmd_a) && (size_after == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PS_IDLE;
         cmd_a    <= '1;
         cmd_b    <= '0;
         rem_size <= '0;
         rem_ofs  <= '0;
         rem_pad  <= '0;
         used     <= '0;
      end else if (dump) begin
         state    <= PS_IDLE;
         cmd_a    <= '1;
         rem_size <= '0;
         rem_ofs  <= '0;
         rem_pad  <= '0;
         used     <= '0;
      end else if (accept) begin
         unique case (state)
            PS_IDLE: begin
               cmd_a <= wr_data & CMDA_KEEP;
               used  <= used + UW'(1);
               state <= PS_CMDB;
            end
            PS_CMDB: begin
               if (a_first(cmd_a)) cmd_b <= wr_data;
               used     <= used + UW'(1);
               rem_size <= a_size(cmd_a);
               rem_ofs  <= a_ofs(cmd_a);
               rem_pad  <= pad_count(a_padm(cmd_a), a_size(cmd_a), a_ofs(cmd_a));
               state    <= PS_DATA;
            end
            PS_DATA: begin
               if (skip_word) begin
                  rem_ofs <= rem_ofs - OFS_W'(4);
               end else begin
                  used <= used + UW'(1);
                  if (pad_word) begin
                     rem_pad <= rem_pad - 3'd1;
                  end else begin
                     rem_size <= size_after;
                     rem_ofs  <= '0;
                  end
                  if (finish) state <= PS_IDLE;
                  if (sent)   used  <= '0;
               end
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

   txp_unpack #(.WORD_W(32)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (dump),
      .load     (emit_load),
      .word     (wr_data),
      .drop     (rem_ofs[1:0]),
      .count    (nbytes),
      .last_in  (emit_last),
      .out_valid(out_valid),
      .out_byte (out_byte),
      .out_last (out_last)
   );

   txp_stat_fifo #(.DEPTH(STAT_DEPTH), .W(TAG_W)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (sent),
      .din     (cmd_b[31:16]),
      .pop     (stat_pop),
      .valid   (stat_valid),
      .head    (stat_word),
      .level   (stat_level),
      .full_hit(full_hit)
   );

   assign fset = {ovf_set, full_hit, ioc_set};

   for (genvar i = 0; i < 3; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= fset[i] | (flags[i] & ~flag_clr[i]);
      end
   end

   assign irq_done      = flags[0];
   assign irq_stat_full = flags[1];
   assign irq_overflow  = flags[2];

endmodule

// File: rtl/txp_chk.sv
module txp_chk #(
   parameter int STAT_DEPTH = 512,
   localparam int SLW = $clog2(STAT_DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           dump,
   input logic [2:0]     flag_clr,
   input logic           out_valid,
   input logic           out_last,
   input logic [SLW-1:0] stat_level,
   input logic           irq_done,
   input logic           irq_stat_full,
   input logic           irq_overflow
);
   p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   p_level_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_level <= SLW'(STAT_DEPTH));

   p_full_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_stat_full) |-> stat_level == SLW'(STAT_DEPTH));

   p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_level == $past(stat_level)) ||
                (stat_level == $past(stat_level) + SLW'(1)) ||
                (stat_level + SLW'(1) == $past(stat_level))));

   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && !flag_clr[0]) |=> irq_done);

   p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_overflow && !flag_clr[2]) |=> irq_overflow);

   p_dump_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dump |=> !out_valid);

endmodule

bind tx_word_parser txp_chk #(.STAT_DEPTH(STAT_DEPTH)) u_txp_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dump         (dump),
   .flag_clr     (flag_clr),
   .out_valid    (out_valid),
   .out_last     (out_last),
   .stat_level   (stat_level),
   .irq_done     (irq_done),
   .irq_stat_full(irq_stat_full),
   .irq_overflow (irq_overflow)
);

// File: tb/tb_tx_word_parser.sv
module tb_tx_word_parser;
   localparam int DW  = 24;
   localparam int SD  = 4;
   localparam int SLW = $clog2(SD + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_valid = 1'b0;
   logic [31:0]    wr_data = '0;
   logic           dump = 1'b0;
   logic           stat_pop = 1'b0;
   logic [2:0]     flag_clr = '0;
   logic           out_valid, out_last, stat_valid;
   logic [7:0]     out_byte;
   logic [15:0]    stat_word;
   logic [SLW-1:0] stat_level;
   logic           irq_done, irq_stat_full, irq_overflow;

   always #2 clk = ~clk;

   tx_word_parser #(.DATA_WORDS(DW), .STAT_DEPTH(SD)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .dump(dump), .stat_pop(stat_pop), .flag_clr(flag_clr),
      .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
      .stat_valid(stat_valid), .stat_word(stat_word), .stat_level(stat_level),
      .irq_done(irq_done), .irq_stat_full(irq_stat_full), .irq_overflow(irq_overflow)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R4";
   logic [8:0] expq[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compare every emitted byte against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, cur_req, "unexpected byte", {23'd0, out_last, out_byte}, 32'h0);
         end else begin
            logic [8:0] e;
            e = expq.pop_front();
            chk({out_last, out_byte} == e, cur_req, "byte/last",
                {23'd0, out_last, out_byte}, {23'd0, e});
         end
      end
   end

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [7:0] pb(input int seed, input int i);
      return 8'(seed * 7 + i * 13 + 1);
   endfunction

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = w;
      @(negedge clk);
      wr_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // builds a buffer from its payload; expected bytes come from the payload
   task automatic send_buf(input bit first, input bit last, input bit ioc,
                           input int size, input int ofs, input int padm,
                           input logic [15:0] tag, input int seed, input int max_words);
      logic [31:0] a;
      int nw, npad, k;
      a = '0;
      a[31]    = ioc;
      a[25:24] = 2'(padm);
      a[20:16] = 5'(ofs);
      a[13]    = first;
      a[12]    = last;
      a[10:0]  = 11'(size);
      nw = (size + ofs + 3) / 4;
      if (padm == 1)      npad = (4 - (nw % 4)) % 4;
      else if (padm == 2) npad = (8 - (nw % 8)) % 8;
      else                npad = 0;
      push_word(a);
      push_word({tag, 16'h3C3C});
      k = 2;
      for (int wi = 0; wi < nw; wi++) begin
         logic [31:0] w;
         for (int b = 0; b < 4; b++) begin
            int idx;
            idx = wi * 4 + b;
            if (idx < ofs) w[b*8 +: 8] = 8'hEE;
            else if (idx - ofs < size) begin
               w[b*8 +: 8] = pb(seed, idx - ofs);
               if (k < max_words)
                  expq.push_back({(last && (idx - ofs == size - 1)), pb(seed, idx - ofs)});
            end else w[b*8 +: 8] = 8'hDD;
         end
         push_word(w);
         k++;
      end
      for (int p = 0; p < npad; p++) push_word(32'hBAD0_BAD0);
   endtask

   task automatic drain(input string req);
      repeat (8) @(negedge clk);
      chk(expq.size() == 0, req, "bytes still expected", expq.size(), 0);
   endtask

   task automatic pop_expect(input logic [15:0] tag, input string req);
      @(negedge clk);
      chk(stat_valid == 1'b1, req, "status valid", {31'd0, stat_valid}, 1);
      chk(stat_word == tag, req, "status tag", {16'd0, stat_word}, {16'd0, tag});
      stat_pop = 1'b1;
      @(negedge clk);
      stat_pop = 1'b0;
   endtask

   task automatic clear_flags(input logic [2:0] m);
      @(negedge clk);
      flag_clr = m;
      @(negedge clk);
      flag_clr = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(out_valid == 1'b0, "R12", "out_valid", {31'd0, out_valid}, 0);
      chk(stat_valid == 1'b0, "R12", "stat_valid", {31'd0, stat_valid}, 0);
      chk(stat_level == '0, "R12", "stat_level", 32'(stat_level), 0);
      chk({irq_done, irq_stat_full, irq_overflow} == 3'b000, "R12", "flags",
          {29'd0, irq_done, irq_stat_full, irq_overflow}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R4 R6 R7 R9: plain buffer, zero offset
      cur_req = "R4";
      send_buf(1, 1, 1, 7, 0, 0, 16'hA1B2, 1, 1 << 30);
      drain("R6");
      chk(irq_done == 1'b1, "R9", "done flag set", {31'd0, irq_done}, 1);
      chk(stat_level == SLW'(1), "R7", "status level", 32'(stat_level), 1);
      pop_expect(16'hA1B2, "R7");
      clear_flags(3'b001);
      chk(irq_done == 1'b0, "R9", "done flag cleared", {31'd0, irq_done}, 0);

      // R4: offset below a word
      cur_req = "R4";
      send_buf(1, 1, 0, 5, 2, 0, 16'h0002, 2, 1 << 30);
      drain("R4");
      pop_expect(16'h0002, "R1");
      chk(irq_done == 1'b0, "R9", "no done without bit 31", {31'd0, irq_done}, 0);

      // R3: offset of two words plus one byte
      cur_req = "R3";
      send_buf(1, 1, 0, 3, 9, 0, 16'h0003, 3, 1 << 30);
      drain("R3");
      pop_expect(16'h0003, "R3");

      // R5: pad modes 1 and 2, then a plain buffer to prove resync
      cur_req = "R5";
      send_buf(1, 1, 0, 4, 0, 1, 16'h0051, 4, 1 << 30);
      send_buf(1, 1, 0, 12, 0, 2, 16'h0052, 5, 1 << 30);
      send_buf(1, 1, 0, 6, 1, 0, 16'h0053, 6, 1 << 30);
      drain("R5");
      pop_expect(16'h0051, "R5");
      pop_expect(16'h0052, "R5");
      pop_expect(16'h0053, "R5");

      // R13 R6 R7: two segments, second tag must not be latched
      cur_req = "R13";
      send_buf(1, 0, 0, 3, 0, 0, 16'h1111, 7, 1 << 30);
      repeat (6) @(negedge clk);
      chk(stat_level == '0, "R7", "no status without last bit", 32'(stat_level), 0);
      send_buf(0, 1, 1, 2, 0, 0, 16'h5555, 8, 1 << 30);
      drain("R13");
      pop_expect(16'h1111, "R13");
      chk(irq_done == 1'b1, "R9", "done after segment", {31'd0, irq_done}, 1);
      clear_flags(3'b001);

      // R8: fill a 4-entry status queue, then one more
      cur_req = "R8";
      for (int i = 0; i < 5; i++)
         send_buf(1, 1, 0, 2, 0, 0, 16'h8000 + 16'(i), 10 + i, 1 << 30);
      drain("R8");
      chk(stat_level == SLW'(SD), "R8", "queue full level", 32'(stat_level), SD);
      chk(irq_stat_full == 1'b1, "R8", "full flag", {31'd0, irq_stat_full}, 1);
      for (int i = 0; i < 4; i++) pop_expect(16'h8000 + 16'(i), "R8");
      chk(stat_valid == 1'b0, "R8", "fifth tag dropped", {31'd0, stat_valid}, 0);
      clear_flags(3'b010);
      chk(irq_overflow == 1'b0, "R10", "count resets after sends", {31'd0, irq_overflow}, 0);

      // R10 R11: overfill the data FIFO count, then dump
      cur_req = "R10";
      send_buf(1, 0, 0, 100, 0, 0, 16'h00AA, 20, DW);
      drain("R10");
      chk(irq_overflow == 1'b1, "R10", "overflow flag", {31'd0, irq_overflow}, 1);
      @(negedge clk); dump = 1'b1; @(negedge clk); dump = 1'b0;
      clear_flags(3'b100);
      cur_req = "R11";
      send_buf(1, 1, 0, 5, 0, 0, 16'h0BB0, 21, 1 << 30);
      drain("R11");
      pop_expect(16'h0BB0, "R11");
      chk(irq_overflow == 1'b0, "R10", "no overflow after dump", {31'd0, irq_overflow}, 0);

      // R11: dump while bytes are still leaving
      cur_req = "R11";
      push_word(32'h0000_3008);
      push_word(32'hCCCC_0000);
      expq.push_back(9'h011);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 32'h4433_2211;
      @(negedge clk);
      wr_valid = 1'b0; dump = 1'b1;
      @(negedge clk);
      dump = 1'b0;
      chk(out_valid == 1'b0, "R11", "bytes stopped", {31'd0, out_valid}, 0);
      drain("R11");
      send_buf(1, 1, 0, 4, 3, 0, 16'h0CC0, 22, 1 << 30);
      drain("R1");
      pop_expect(16'h0CC0, "R11");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule